// File: doc/BRIEF.md
# Calibrated Two-Stage Clock Prescaler

This block turns a nominal 32.768 kHz clock into two timing strobes. A first programmable divider emits an intermediate tick once every `prediv_a + 1` input cycles. A second divider counts those ticks and emits a seconds tick once every `prediv_s + 1` of them. Both dividers are plain counters in the input clock domain, and each tick is a strobe one clock cycle wide. The block generates no derived clocks.

A digital trim corrects for a crystal that runs fast or slow. The block counts seconds and minutes internally. In the last second of every period of `cal_per + 1` minutes it shortens or lengthens that second by `cal_dc` intermediate ticks. New trim settings arrive through a write strobe and are held as pending until they are applied a couple of intermediate ticks later. Any write made while a change is pending is dropped. A small output selector routes the alarm pulse, the seconds tick or the intermediate tick to one output pin, or drives the pin low.

Top module: `cal_prescaler`

## Requirements
- R1: `apre_tick` is a one-cycle strobe that occurs once every `prediv_a + 1` clock cycles.
- R2: With trim disabled, `spre_tick` occurs once every `(prediv_a + 1) * (prediv_s + 1)` clock cycles, and only in a cycle where `apre_tick` is high.
- R3: Seconds are numbered 1, 2, ... from reset release. Second n is the trimmed second exactly when trim is enabled and n is a multiple of `60 * (cal_per + 1)`.
- R4: With `cal_neg` = 0, the trimmed second lasts `prediv_s + 1 - cal_dc` intermediate ticks, so it ends sooner. The caller keeps `cal_dc < prediv_s`.
- R5: With `cal_neg` = 1, the trimmed second lasts `prediv_s + 1 + cal_dc` intermediate ticks, so it ends later.
- R6: With `cal_en` = 0, every second lasts `prediv_s + 1` intermediate ticks.
- R7: A `cal_wr` pulse while `cal_pending` is low raises `cal_pending` on the next cycle. The written settings become active, and `cal_pending` falls, at the clock edge of the second `apre_tick` after the write.
- R8: A `cal_wr` pulse while `cal_pending` is high is ignored. The settings that finally take effect are those of the accepted write.
- R9: `out_sel` picks what drives `out_pin`: 00 gives a constant low, 01 gives `alarm_in`, 10 gives `spre_tick` and 11 gives `apre_tick`.
- R10: A `cal_wr` pulse in the same cycle as a `spre_tick` is accepted, and the seconds sequence is not disturbed.
- R11: While reset is held, all counters are zero, `cal_pending` is low and trim is inactive. `apre_tick` and `spre_tick` are low whenever `prediv_a` is not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, nominally 32.768 kHz |
| rst_n | input | 1 | Asynchronous reset, active low |
| prediv_a | input | 9 | First divider terminal value; the divide ratio is this value plus 1 |
| prediv_s | input | 9 | Second divider terminal value; the divide ratio is this value plus 1 |
| cal_wr | input | 1 | Write strobe for the trim settings |
| cal_en | input | 1 | Trim enable (write data) |
| cal_neg | input | 1 | Trim sign: 0 makes seconds shorter, 1 makes them longer (write data) |
| cal_dc | input | 7 | Number of intermediate ticks to add or remove (write data) |
| cal_per | input | 3 | Trim period in minutes, minus one (write data) |
| out_sel | input | 2 | Selector for the output pin |
| alarm_in | input | 1 | Alarm pulse that can be routed to the pin |
| apre_tick | output | 1 | Intermediate tick strobe |
| spre_tick | output | 1 | Seconds tick strobe |
| cal_pending | output | 1 | High while accepted trim settings wait to be applied |
| out_pin | output | 1 | Routed output |

## Verification
A settings write and the end of a second are handled by separate logic, so they can fall on the same clock edge. The bench provokes this by waiting for a sample in which `spre_tick` is high and raising `cal_wr` in that same cycle. It then judges the result at the ports: `cal_pending` must be high on the next sample, and the following second must have its normal length. A second collision comes from the ignored-write vector, where a second write reaches the block while the first is still pending. The length of the trimmed second then shows which settings actually took effect.

// File: rtl/calpre_pkg.sv
package calpre_pkg;
  localparam int DC_W  = 7;
  localparam int PER_W = 3;

  typedef enum logic [1:0] {
    OSEL_OFF   = 2'b00,
    OSEL_ALARM = 2'b01,
    OSEL_SEC   = 2'b10,
    OSEL_INT   = 2'b11
  } osel_e;

  typedef struct packed {
    logic             en;
    logic             neg;
    logic [DC_W-1:0]  dc;
    logic [PER_W-1:0] per;
  } cal_cfg_t;
endpackage

// File: rtl/apre_div.sv
module apre_div #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] div_max,
  output logic         tick
);
  logic [W-1:0] cnt;

  // terminal detect; >= recovers if div_max is lowered under the count
  assign tick = (cnt >= div_max);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R1: a tick restarts the count, so no second tick follows at once
  assert_tick_isolated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_max != '0) |=> (!tick || div_max == '0));
endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import calpre_pkg::*;
#(
  parameter int APPLY_TICKS = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     apre_tick,
  input  logic     wr,
  input  cal_cfg_t cfg_in,
  output cal_cfg_t cfg_act,
  output logic     pending
);
  localparam int TC_W = (APPLY_TICKS > 2) ? $clog2(APPLY_TICKS) : 1;

  cal_cfg_t       stage;
  logic [TC_W-1:0] tcnt;
  logic            accept;
  logic            apply_now;

  assign accept    = wr && !pending;
  assign apply_now = pending && apre_tick && (tcnt == TC_W'(APPLY_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage   <= '0;
      cfg_act <= '0;
      pending <= 1'b0;
      tcnt    <= '0;
    end else if (accept) begin
      stage   <= cfg_in;
      pending <= 1'b1;
      tcnt    <= '0;
    end else if (apply_now) begin
      cfg_act <= stage;
      pending <= 1'b0;
    end else if (pending && apre_tick) begin
      tcnt <= tcnt + 1'b1;
    end
  end

  assert_wr_sets_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !pending) |=> pending);
  assert_wr_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && pending) |=> $stable(stage));
  assert_apply_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> (cfg_act == stage));
endmodule

// File: rtl/spre_div.sv
module spre_div
  import calpre_pkg::*;
#(
  parameter int S_W          = 9,
  parameter int SECS_PER_MIN = 60
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           apre_tick,
  input  logic [S_W-1:0] div_max,
  input  cal_cfg_t       cfg,
  output logic           tick,
  output logic           corr_window
);
  localparam int TW    = S_W + 1;
  localparam int SEC_W = $clog2(SECS_PER_MIN);

  // terminal count of the current second; trimmed only inside the window
  function automatic logic [TW-1:0] sec_terminal(
    input logic [S_W-1:0]  base,
    input logic [DC_W-1:0] dc,
    input logic            neg,
    input logic            corr
  );
    logic [TW-1:0] b;
    b = {1'b0, base};
    if (!corr)   return b;
    else if (neg) return b + TW'(dc);
    else          return b - TW'(dc);
  endfunction

  logic [TW-1:0]    scnt;
  logic [SEC_W-1:0] sec_cnt;
  logic [PER_W-1:0] min_cnt;
  logic             last_sec;
  logic             last_min;
  logic [TW-1:0]    term;

  assign last_sec    = (sec_cnt == SEC_W'(SECS_PER_MIN - 1));
  assign last_min    = (min_cnt >= cfg.per);
  assign corr_window = cfg.en && last_sec && last_min;
  assign term        = sec_terminal(div_max, cfg.dc, cfg.neg, corr_window);
  assign tick        = apre_tick && (scnt >= term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt    <= '0;
      sec_cnt <= '0;
      min_cnt <= '0;
    end else if (apre_tick) begin
      if (tick) begin
        scnt <= '0;
        if (last_sec) begin
          sec_cnt <= '0;
          min_cnt <= last_min ? '0 : min_cnt + 1'b1;
        end else begin
          sec_cnt <= sec_cnt + 1'b1;
        end
      end else begin
        scnt <= scnt + 1'b1;
      end
    end
  end

  // R3: the trimmed second closes a period, so both counters restart
  assert_period_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && corr_window) |=> (sec_cnt == '0 && min_cnt == '0));
endmodule

// File: rtl/cal_prescaler.sv
module cal_prescaler
  import calpre_pkg::*;
#(
  parameter int A_W          = 9,
  parameter int S_W          = 9,
  parameter int SECS_PER_MIN = 60,
  parameter int APPLY_TICKS  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [A_W-1:0]   prediv_a,
  input  logic [S_W-1:0]   prediv_s,
  input  logic             cal_wr,
  input  logic             cal_en,
  input  logic             cal_neg,
  input  logic [DC_W-1:0]  cal_dc,
  input  logic [PER_W-1:0] cal_per,
  input  logic [1:0]       out_sel,
  input  logic             alarm_in,
  output logic             apre_tick,
  output logic             spre_tick,
  output logic             cal_pending,
  output logic             out_pin
);
  cal_cfg_t cfg_wr;
  cal_cfg_t cfg_act;
  logic     corr_window;

  assign cfg_wr = '{en: cal_en, neg: cal_neg, dc: cal_dc, per: cal_per};

  apre_div #(.W(A_W)) u_apre (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_max (prediv_a),
    .tick    (apre_tick)
  );

  cal_ctrl #(.APPLY_TICKS(APPLY_TICKS)) u_cal (
    .clk       (clk),
    .rst_n     (rst_n),
    .apre_tick (apre_tick),
    .wr        (cal_wr),
    .cfg_in    (cfg_wr),
    .cfg_act   (cfg_act),
    .pending   (cal_pending)
  );

  spre_div #(.S_W(S_W), .SECS_PER_MIN(SECS_PER_MIN)) u_spre (
    .clk         (clk),
    .rst_n       (rst_n),
    .apre_tick   (apre_tick),
    .div_max     (prediv_s),
    .cfg         (cfg_act),
    .tick        (spre_tick),
    .corr_window (corr_window)
  );

  always_comb begin
    case (osel_e'(out_sel))
      OSEL_ALARM: out_pin = alarm_in;
      OSEL_SEC:   out_pin = spre_tick;
      OSEL_INT:   out_pin = apre_tick;
      default:    out_pin = 1'b0;
    endcase
  end

  // R2: the seconds tick only lands on an intermediate tick
  assert_sec_on_int_R2: assert property (@(posedge clk) disable iff (!rst_n)
    spre_tick |-> apre_tick);
  // R9: with the seconds tick selected, the pin stays low between ticks
  assert_out_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sel == 2'b10 && !spre_tick) |-> !out_pin);
endmodule

// File: tb/test_cal_prescaler.sv
`timescale 1ns/1ps
module test_cal_prescaler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] prediv_a = 9'd3;
  logic [8:0] prediv_s = 9'd9;
  logic       cal_wr = 1'b0;
  logic       cal_en = 1'b0;
  logic       cal_neg = 1'b0;
  logic [6:0] cal_dc = '0;
  logic [2:0] cal_per = '0;
  logic [1:0] out_sel = 2'b10;
  logic       alarm_in = 1'b0;
  logic       apre_tick, spre_tick, cal_pending, out_pin;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  cal_prescaler i_cal_prescaler (
    .clk(clk), .rst_n(rst_n), .prediv_a(prediv_a), .prediv_s(prediv_s),
    .cal_wr(cal_wr), .cal_en(cal_en), .cal_neg(cal_neg), .cal_dc(cal_dc),
    .cal_per(cal_per), .out_sel(out_sel), .alarm_in(alarm_in),
    .apre_tick(apre_tick), .spre_tick(spre_tick), .cal_pending(cal_pending),
    .out_pin(out_pin)
  );

  // fields: prediv_a, prediv_s, en, neg, dc, per, dc of a blocked second write
  localparam int NV = 5;
  localparam int VEC [NV][7] = '{
    '{0, 9, 0, 0, 3, 0, 3},
    '{0, 9, 1, 0, 3, 0, 6},
    '{1, 9, 1, 1, 4, 0, 4},
    '{0, 7, 1, 0, 5, 1, 5},
    '{2, 4, 1, 1, 2, 0, 1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int a, input int s);
    @(negedge clk);
    rst_n = 1'b0; cal_wr = 1'b0;
    prediv_a = 9'(a); prediv_s = 9'(s);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // walk seconds from reset release; second k ends at pulse k
  task automatic run_vec(input int v);
    int a = VEC[v][0]; int s = VEC[v][1]; int en = VEC[v][2];
    int ng = VEC[v][3]; int dc = VEC[v][4]; int per = VEC[v][5];
    int igdc = VEC[v][6];
    int span = 60 * (per + 1);
    int npulse = 2 * span;
    int t = 0; int last = 0; int k = 0; int bad = 0;
    int first_act = 0; int first_exp = 0; int corr_seen = 0;
    do_reset(a, s);
    while (k < npulse && t < 20000) begin
      @(negedge clk);
      t++;
      if (spre_tick) begin
        k++;
        if (k >= 2) begin
          int exp;
          if (en != 0 && (k % span) == 0) begin
            exp = (a + 1) * (ng != 0 ? s + 1 + dc : s + 1 - dc);
            corr_seen++;
          end else begin
            exp = (a + 1) * (s + 1);
          end
          if (t - last != exp) begin
            if (bad == 0) begin first_act = t - last; first_exp = exp; end
            bad++;
          end
        end
        last = t;
      end
      cal_wr = 1'b0;
      if (t == 1) begin
        cal_wr = 1'b1; cal_en = en[0]; cal_neg = ng[0];
        cal_dc = 7'(dc); cal_per = 3'(per);
      end else if (t == 2 && igdc != dc) begin
        cal_wr = 1'b1; cal_dc = 7'(igdc);  // R8: lands while pending
      end
    end
    cal_wr = 1'b0;
    check($sformatf("R3 vec%0d seconds observed", v), k, npulse);
    if (en == 0)
      check($sformatf("R2 R6 vec%0d interval", v), bad == 0 ? 0 : first_act, 0);
    else if (ng != 0)
      check($sformatf("R5 R3 vec%0d interval", v), bad == 0 ? 0 : first_act,
            bad == 0 ? 0 : first_exp);
    else
      check($sformatf("R4 R3 R8 vec%0d interval", v), bad == 0 ? 0 : first_act,
            bad == 0 ? 0 : first_exp);
    if (en != 0) check($sformatf("R3 vec%0d trimmed seconds", v), corr_seen, 2);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R11: reset state with nonzero prediv_a
    repeat (2) @(negedge clk);
    check("R11 reset apre_tick", int'(apre_tick), 0);
    check("R11 reset spre_tick", int'(spre_tick), 0);
    check("R11 reset cal_pending", int'(cal_pending), 0);
    check("R11 reset out_pin", int'(out_pin), 0);

    for (int v = 0; v < NV; v++) run_vec(v);

    // R1 and R7: intermediate tick spacing and pending handshake
    begin
      int gaps_bad = 0; int lastt = -1; int ticks_pend = 0; int n = 0;
      do_reset(3, 9);
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (apre_tick) begin
          if (lastt >= 0 && i - lastt != 4) gaps_bad++;
          lastt = i;
        end
      end
      check("R1 intermediate tick spacing", gaps_bad, 0);
      cal_wr = 1'b1; cal_en = 1'b1; cal_neg = 1'b0; cal_dc = 7'd2; cal_per = 3'd0;
      @(negedge clk);
      cal_wr = 1'b0;
      check("R7 pending raised", int'(cal_pending), 1);
      while (cal_pending && n < 50) begin
        if (apre_tick) ticks_pend++;
        @(negedge clk);
        n++;
      end
      check("R7 ticks until applied", ticks_pend, 2);
      check("R7 pending cleared", int'(cal_pending), 0);
    end

    // R9: output selector
    begin
      do_reset(1, 2);
      for (int sel = 0; sel < 4; sel++) begin
        int bad = 0; int got = 0; int exp_v = 0;
        out_sel = 2'(sel);
        for (int i = 0; i < 40; i++) begin
          alarm_in = (i % 3 == 0);
          @(negedge clk);
          case (sel)
            0: exp_v = 0;
            1: exp_v = int'(alarm_in);
            2: exp_v = int'(spre_tick);
            default: exp_v = int'(apre_tick);
          endcase
          if (int'(out_pin) != exp_v) begin bad++; got = int'(out_pin); end
        end
        check($sformatf("R9 out_sel=%0d mismatches", sel), bad, 0);
      end
      out_sel = 2'b10; alarm_in = 1'b0;
    end

    // R10: write in the same cycle as a seconds tick
    begin
      int n = 0; int gap = 0;
      do_reset(0, 9);
      while (!spre_tick && n < 100) begin @(negedge clk); n++; end
      cal_wr = 1'b1; cal_en = 1'b0; cal_neg = 1'b0; cal_dc = 7'd1; cal_per = 3'd0;
      @(negedge clk);
      cal_wr = 1'b0;
      check("R10 pending after coincident write", int'(cal_pending), 1);
      gap = 1;
      while (!spre_tick && gap < 100) begin @(negedge clk); gap++; end
      check("R10 following second length", gap, 10);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule